// File: doc/BRIEF.md
# Banked Program Counter with Return Stack

This block sequences instruction fetch for a small controller whose program space is split into 8K-word banks. It keeps a 16-bit program counter whose value is the fetch address, an 8-bit bank-select register whose bits 7..5 name a bank, and a hardware return stack. Each clock the instruction decoder issues one request: hold, step to the next word, jump, call, return, or take an interrupt.

Jump and call requests carry only a 13-bit in-bank address. The bank bits of the new counter value come from the bank-select register as it stands in that cycle. Bank n therefore spans n×2000H to n×2000H+1FFFH. Call and interrupt entry save the address of the following word on the stack, and return restores it. The stack is a fixed-depth ring: it never refuses a push and never blocks a pop.

Top module: `banked_pc_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fetch_addr_o` becomes 0000H, `bank_rdata_o` becomes 00H and the stack is emptied with all slots cleared.
- R2: Request codes on `op_i` are 0 hold, 1 step, 2 jump, 3 call, 4 return, 5 interrupt. Codes 0, 6 and 7 leave the counter and the stack unchanged.
- R3: A step sets the counter to its value plus one, modulo 2^16 (FFFFH steps to 0000H), and leaves the bank-select register untouched.
- R4: A jump loads {bank-select bits 7..5, `target_i`}, using the register value held before that edge, even when a write to it occurs in the same cycle.
- R5: A call pushes the counter plus one (modulo 2^16) and then loads the counter as a jump does.
- R6: A return loads the most recently pushed entry that has not been popped yet, in last-in first-out order.
- R7: An interrupt pushes the counter plus one and loads the vector 0004H in bank 0, whatever the bank-select register holds.
- R8: With the default depth of 8, a push onto a full stack discards the oldest entry. The next 8 returns yield the 8 newest entries.
- R9: A return on an empty stack loads the last entry popped, or 0000H if nothing has been popped since reset. The stack stays empty.
- R10: When `bank_we_i` is high, `bank_wdata_i` is stored in all 8 bits of the bank-select register at the clock edge. `bank_rdata_o` shows the stored value from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Sequencing request code |
| target_i | input | 13 | In-bank target for jump and call |
| bank_we_i | input | 1 | Bank-select register write enable |
| bank_wdata_i | input | 8 | Bank-select register write data |
| fetch_addr_o | output | 16 | Program counter, used as the fetch address |
| bank_rdata_o | output | 8 | Bank-select register contents |

## Verification
The bench drives a long run of pushes past the stack depth and then unwinds it. A design that stopped pushing when full, or that overwrote the newest slot, would return wrong addresses on the later returns. It also issues returns on a reset-fresh stack and on a freshly drained stack. A design that let the pointer drift on an empty pop would return stale or shifted entries. Other cases cover a bank-select write in the same cycle as a jump, where a design that forwarded the new value would land in the wrong bank, and the step from FFFFH, which must wrap to 0000H. Illegal codes are issued to show they neither move the counter nor touch the stack.

// File: rtl/pcs_pkg.sv
// Shared request codes for the banked program sequencer.
// Assumes the decoder presents exactly one request code per cycle.
package pcs_pkg;
    typedef enum logic [2:0] {
        PCS_HOLD = 3'd0,
        PCS_STEP = 3'd1,
        PCS_JUMP = 3'd2,
        PCS_CALL = 3'd3,
        PCS_RET  = 3'd4,
        PCS_IRQ  = 3'd5
    } pcs_op_e;
endpackage

// File: rtl/pcs_bank_reg.sv
// Bank-select register: a plain write-enabled register with a read port.
// Assumes writes take effect at the edge and are seen from the next cycle.
module pcs_bank_reg #(
    parameter int BP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [BP_W-1:0] wdata,
    output logic [BP_W-1:0] q
);
    // Store the written value; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    // R3/R10: the register only moves on an explicit write.
    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
    assert_bank_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(wdata));
endmodule

// File: rtl/pcs_ret_stack.sv
// Ring-buffer return stack. A push when full overwrites the oldest entry.
// A pop when empty returns the slot last popped and leaves the pointer alone.
// Assumes push and pop never occur in the same cycle.
module pcs_ret_stack #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp;
    logic [CNT_W-1:0]  cnt;
    logic [PTR_W-1:0]  wp_inc, wp_dec;

    // Neighbouring slot indices with wrap for any depth.
    always_comb begin
        wp_inc = (wp == LAST) ? '0 : wp + 1'b1;
        wp_dec = (wp == '0) ? LAST : wp - 1'b1;
    end

    // Read the top entry, or the last popped slot when empty.
    always_comb begin
        pop_data = (cnt != '0) ? mem[wp_dec] : mem[wp];
    end

    // Update pointer, occupancy and storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[wp] <= push_data;
            wp      <= wp_inc;
            if (cnt != FULL) cnt <= cnt + 1'b1;
        end else if (pop && cnt != '0) begin
            wp  <= wp_dec;
            cnt <= cnt - 1'b1;
        end
    end

    assert_one_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    assert_full_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt == FULL) |=> cnt == FULL);
    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt == '0) |=> (cnt == '0 && $stable(wp)));
    assert_push_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> mem[$past(wp)] == $past(push_data));
endmodule

// File: rtl/pcs_next_pc.sv
// Next-address selection and stack request generation for one request code.
// Assumes the bank field and popped data are valid in the same cycle.
module pcs_next_pc
    import pcs_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int OFS_W   = 13,
    parameter int IRQ_OFS = 4
) (
    input  logic [2:0]            op,
    input  logic [PC_W-1:0]       pc,
    input  logic [OFS_W-1:0]      target,
    input  logic [PC_W-OFS_W-1:0] bank,
    input  logic [PC_W-1:0]       pop_data,
    output logic [PC_W-1:0]       pc_next,
    output logic                  push,
    output logic                  pop,
    output logic [PC_W-1:0]       push_data
);
    localparam int BANK_W = PC_W - OFS_W;
    localparam logic [PC_W-1:0] VECTOR = {{BANK_W{1'b0}}, OFS_W'(IRQ_OFS)};

    logic [PC_W-1:0] pc_inc;

    // Decode the request into an address choice and stack action.
    always_comb begin
        pc_inc    = pc + 1'b1;
        pc_next   = pc;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = pc_inc;
        case (pcs_op_e'(op))
            PCS_STEP: pc_next = pc_inc;
            PCS_JUMP: pc_next = {bank, target};
            PCS_CALL: begin
                push    = 1'b1;
                pc_next = {bank, target};
            end
            PCS_RET: begin
                pop     = 1'b1;
                pc_next = pop_data;
            end
            PCS_IRQ: begin
                push    = 1'b1;
                pc_next = VECTOR;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/banked_pc_seq.sv
// Banked program sequencer top: program counter, bank-select register
// and return stack. Assumes one request per cycle from the decoder.
module banked_pc_seq
    import pcs_pkg::*;
#(
    parameter int PC_W        = 16,
    parameter int OFS_W       = 13,
    parameter int BP_W        = 8,
    parameter int BANK_LSB    = 5,
    parameter int STACK_DEPTH = 8,
    parameter int IRQ_OFS     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [OFS_W-1:0] target_i,
    input  logic             bank_we_i,
    input  logic [BP_W-1:0]  bank_wdata_i,
    output logic [PC_W-1:0]  fetch_addr_o,
    output logic [BP_W-1:0]  bank_rdata_o
);
    localparam int BANK_W   = PC_W - OFS_W;
    localparam int BANK_MSB = BANK_LSB + BANK_W - 1;

    logic [PC_W-1:0]   pc_q, pc_next, push_data, pop_data;
    logic              push, pop;
    logic [BP_W-1:0]   bp_q;
    logic [BANK_W-1:0] bank;

    assign bank = bp_q[BANK_MSB:BANK_LSB];

    pcs_bank_reg #(.BP_W(BP_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we_i), .wdata(bank_wdata_i), .q(bp_q)
    );

    pcs_ret_stack #(.DATA_W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_data(push_data), .pop_data(pop_data)
    );

    pcs_next_pc #(.PC_W(PC_W), .OFS_W(OFS_W), .IRQ_OFS(IRQ_OFS)) u_next (
        .op(op_i), .pc(pc_q), .target(target_i), .bank(bank), .pop_data(pop_data),
        .pc_next(pc_next), .push(push), .pop(pop), .push_data(push_data)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign fetch_addr_o = pc_q;
    assign bank_rdata_o = bp_q;

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> pc_q == PC_W'($past(pc_q) + 1'b1));
    assert_jump_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2) |=> pc_q == {$past(bp_q[BANK_MSB:BANK_LSB]), $past(target_i)});
    assert_call_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> pc_q[PC_W-1:OFS_W] == $past(bp_q[BANK_MSB:BANK_LSB]));
    assert_irq_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |=> pc_q == PC_W'(IRQ_OFS));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7) |=> $stable(pc_q));
endmodule

// File: tb/banked_pc_seq_tb.sv
`timescale 1ns/1ps
module banked_pc_seq_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [12:0] target_i = '0;
    logic        bank_we_i = 1'b0;
    logic [7:0]  bank_wdata_i = '0;
    logic [15:0] fetch_addr_o;
    logic [7:0]  bank_rdata_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] m_pc;
    logic [7:0]  m_bp;
    logic [15:0] m_stk[$];
    logic [15:0] m_bottom;

    banked_pc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .target_i(target_i),
        .bank_we_i(bank_we_i), .bank_wdata_i(bank_wdata_i),
        .fetch_addr_o(fetch_addr_o), .bank_rdata_o(bank_rdata_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] jump_addr(logic [7:0] bp, logic [12:0] t);
        return {bp[7:5], t};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one request at a falling edge, update model, check next falling edge.
    task automatic step(logic [2:0] op, logic [12:0] t, logic we, logic [7:0] wd, string req);
        logic [15:0] nxt;
        op_i = op; target_i = t; bank_we_i = we; bank_wdata_i = wd;
        nxt = m_pc;
        case (op)
            3'd1: nxt = m_pc + 16'd1;
            3'd2: nxt = jump_addr(m_bp, t);
            3'd3: begin
                m_stk.push_back(m_pc + 16'd1);
                if (m_stk.size() > DEPTH) void'(m_stk.pop_front());
                nxt = jump_addr(m_bp, t);
            end
            3'd4: begin
                if (m_stk.size() > 0) begin
                    nxt = m_stk.pop_back();
                    m_bottom = nxt;
                end else nxt = m_bottom;
            end
            3'd5: begin
                m_stk.push_back(m_pc + 16'd1);
                if (m_stk.size() > DEPTH) void'(m_stk.pop_front());
                nxt = 16'h0004;
            end
            default: ;
        endcase
        if (we) m_bp = wd;
        m_pc = nxt;
        @(posedge clk);
        @(negedge clk);
        check(req, fetch_addr_o, m_pc);
        check("R10", {8'h0, bank_rdata_o}, {8'h0, m_bp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_pc = '0; m_bp = '0; m_bottom = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", fetch_addr_o, 16'h0000);
        check("R1", {8'h0, bank_rdata_o}, 16'h0000);
        rst_n = 1'b1;

        // R9: empty pop after reset yields 0000H
        step(3'd1, 0, 0, 0, "R3");
        step(3'd4, 0, 0, 0, "R9");
        // R2: illegal codes hold
        step(3'd1, 0, 0, 0, "R3");
        step(3'd6, 13'h1555, 0, 0, "R2");
        step(3'd7, 13'h0AAA, 0, 0, "R2");
        step(3'd0, 13'h0123, 0, 0, "R2");
        // R10 then R4: write applies next cycle; same-cycle jump uses old bank
        step(3'd0, 0, 1, 8'hA0, "R10");
        step(3'd2, 13'h0100, 1, 8'hE0, "R4");
        step(3'd2, 13'h1FFF, 0, 0, "R4");
        // R3: wrap FFFF -> 0000, bank unchanged
        step(3'd1, 0, 0, 0, "R3");
        // R5/R6: nested calls and returns
        step(3'd3, 13'h0040, 1, 8'h20, "R5");
        step(3'd3, 13'h0080, 0, 0, "R5");
        step(3'd5, 0, 0, 0, "R7");
        step(3'd4, 0, 0, 0, "R6");
        step(3'd4, 0, 0, 0, "R6");
        step(3'd4, 0, 0, 0, "R6");
        // R9: drained stack returns last popped
        step(3'd4, 0, 0, 0, "R9");
        step(3'd4, 0, 0, 0, "R9");
        // R8: overflow by 3 then unwind past empty
        for (int i = 0; i < DEPTH + 3; i++) step(3'd3, 13'(i * 7 + 1), 0, 0, "R8");
        for (int i = 0; i < DEPTH + 2; i++) step(3'd4, 0, 0, 0, "R8");
        // R7: interrupt ignores bank select
        step(3'd0, 0, 1, 8'hFF, "R10");
        step(3'd5, 0, 0, 0, "R7");
        step(3'd4, 0, 0, 0, "R6");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [2:0] op;
            r = $urandom_range(0, 99);
            if      (r < 25) op = 3'd1;
            else if (r < 40) op = 3'd2;
            else if (r < 60) op = 3'd3;
            else if (r < 80) op = 3'd4;
            else if (r < 90) op = 3'd5;
            else             op = 3'($urandom_range(6, 8) % 8);
            step(op, 13'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom), "R6");
        end

        // Reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", fetch_addr_o, 16'h0000);
        check("R1", {8'h0, bank_rdata_o}, 16'h0000);
        rst_n = 1'b1;
        m_pc = '0; m_bp = '0; m_bottom = '0; m_stk.delete();
        step(3'd4, 0, 0, 0, "R1");
        finish_run();
    end
endmodule